// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block drives the four switches of one full H-bridge winding: two high-side gates (leg A and leg B) and two low-side gates (leg A and leg B). A controller asks for one of four bridge modes: off, charge, slow decay or fast decay. A separate bit gives the direction in which current flows through the winding. The sequencer turns each request into the matching gate pattern. The pattern depends on direction in charge and in fast decay. In slow decay both low-side switches conduct in either direction.

A bridge must never pass straight from one switch pattern to another. Whenever the request changes, the sequencer therefore removes every gate at once and waits a programmable number of clocks before it applies the new pattern. A request that arrives while that wait is running starts the wait again, and only the latest request is applied. A low enable input or a high thermal-fault input also takes every gate down at once, so the coil current freewheels through the body diodes. A thermal fault also drives a protect indication that an open-drain pad would use: driven while the fault is present, released otherwise. When enable or the fault clears, the full wait runs again before any switch closes.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Forward direction (dir_rev=0), with gates written {hs_a,hs_b,ls_a,ls_b}: charge (mode_req=01) gives 1001, slow decay (10) gives 0011, fast decay (11) gives 0110, and off (00) gives 0000.
- R2: Reverse direction (dir_rev=1): charge gives 0110, slow decay gives 0011, fast decay gives 1001, and off gives 0000.
- R3: Any change of mode_req or dir_rev drives all gates low in the same cycle. Counting the first rising edge that samples the new request as edge 1, the gates stay low through edge DEAD_CYC. The new pattern appears after edge DEAD_CYC+1. No nonzero pattern is ever followed directly by a different nonzero pattern.
- R4: While enable is low, all four gates are low, starting in the same cycle that enable falls.
- R5: hs_a and ls_a are never high together, and hs_b and ls_b are never high together.
- R6: While therm_fault is high, all gates are low in the same cycle and prot_pull is high. While therm_fault is low, prot_pull is low.
- R7: A request change that arrives while the dead time is running restarts the full dead time. The pattern then applied is that of the latest request.
- R8: After enable returns high, or therm_fault returns low, with an unchanged request, the pattern reappears only after DEAD_CYC rising edges. Edge 1 is the first edge at which the block is no longer held off.
- R9: During and after reset, with the off request held, all gates are low and prot_pull follows therm_fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req | input | 2 | Bridge mode: 00 off, 01 charge, 10 slow decay, 11 fast decay |
| dir_rev | input | 1 | Current direction: 0 forward, 1 reverse |
| enable | input | 1 | High allows switching; low forces all gates off |
| therm_fault | input | 1 | High forces all gates off and raises prot_pull |
| gate_hs_a | output | 1 | High-side switch, leg A |
| gate_hs_b | output | 1 | High-side switch, leg B |
| gate_ls_a | output | 1 | Low-side switch, leg A |
| gate_ls_b | output | 1 | Low-side switch, leg B |
| prot_pull | output | 1 | High while the fault pad should be actively driven |

## Verification
Assertions check four things on every cycle: that neither leg ever conducts top-to-bottom, that enable low or a fault leaves every gate off, that a nonzero pattern never turns straight into another, and that a request change always restarts the blanking. The length of the dead time is shown only by the bench's scenarios, because it is a count of edges. The same holds for which pattern finally appears after a restarted wait and for the recovery delay after enable or the fault clears. The bench measures these against its own table of patterns and its own edge count.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    BR_OFF    = 2'b00,
    BR_CHARGE = 2'b01,
    BR_SLOW   = 2'b10,
    BR_FAST   = 2'b11
  } br_mode_e;

  typedef struct packed {
    br_mode_e mode;
    logic     rev;
  } br_req_t;

  typedef struct packed {
    logic hs_a;
    logic hs_b;
    logic ls_a;
    logic ls_b;
  } gate_set_t;

  // Current is sourced from leg A (into the winding from the A side) or
  // from leg B. Charge and fast decay swap sides; slow decay shorts both lows.
  function automatic gate_set_t switch_map(br_req_t r);
    gate_set_t g;
    logic src_a;
    logic src_b;
    logic short_low;
    src_a     = ((r.mode == BR_CHARGE) && !r.rev) || ((r.mode == BR_FAST) && r.rev);
    src_b     = ((r.mode == BR_CHARGE) &&  r.rev) || ((r.mode == BR_FAST) && !r.rev);
    short_low = (r.mode == BR_SLOW);
    g.hs_a = src_a;
    g.hs_b = src_b;
    g.ls_a = src_b | short_low;
    g.ls_b = src_a | short_low;
    return g;
  endfunction

  function automatic logic wait_done(int unsigned quiet, int unsigned limit);
    return quiet >= limit;
  endfunction

endpackage

// File: rtl/hbg_blank_timer.sv
module hbg_blank_timer
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 75
) (
  input  logic    clk,
  input  logic    rst_n,
  input  br_req_t req,
  input  logic    hold_off,
  output br_req_t held,
  output logic    req_change,
  output logic    settled
);

  localparam int unsigned CW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);

  logic [CW-1:0] quiet_q;
  br_req_t       held_q;

  assign req_change = (req != held_q);
  assign held       = held_q;
  assign settled    = wait_done(int'(quiet_q), DEAD_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '{mode: BR_OFF, rev: 1'b0};
      quiet_q <= '0;
    end else if (hold_off) begin
      quiet_q <= '0;
    end else if (req_change) begin
      held_q  <= req;
      quiet_q <= '0;
    end else if (quiet_q != LIMIT) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_change |=> !settled); // R7

endmodule

// File: rtl/hbg_gate_out.sv
module hbg_gate_out
  import hbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  br_req_t   held,
  input  logic      settled,
  input  logic      req_change,
  input  logic      enable,
  input  logic      therm_fault,
  output gate_set_t gates
);

  logic      allow;
  gate_set_t wanted;

  assign wanted = switch_map(held);
  assign allow  = settled && enable && !therm_fault && !req_change;
  assign gates  = allow ? wanted : '0;

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates.hs_a && gates.ls_a)); // R5
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates.hs_b && gates.ls_b)); // R5
  AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (gates == '0)); // R4
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    therm_fault |-> (gates == '0)); // R6
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((gates != '0) && ($past(gates) != '0)) |-> (gates == $past(gates))); // R3

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       dir_rev,
  input  logic       enable,
  input  logic       therm_fault,
  output logic       gate_hs_a,
  output logic       gate_hs_b,
  output logic       gate_ls_a,
  output logic       gate_ls_b,
  output logic       prot_pull
);

  br_req_t   req_now;
  br_req_t   held;
  logic      hold_off;
  logic      req_change;
  logic      settled;
  gate_set_t gates;

  assign req_now  = '{mode: br_mode_e'(mode_req), rev: dir_rev};
  assign hold_off = !enable || therm_fault;

  hbg_blank_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_now),
    .hold_off   (hold_off),
    .held       (held),
    .req_change (req_change),
    .settled    (settled)
  );

  hbg_gate_out u_gates (
    .clk         (clk),
    .rst_n       (rst_n),
    .held        (held),
    .settled     (settled),
    .req_change  (req_change),
    .enable      (enable),
    .therm_fault (therm_fault),
    .gates       (gates)
  );

  assign gate_hs_a = gates.hs_a;
  assign gate_hs_b = gates.hs_b;
  assign gate_ls_a = gates.ls_a;
  assign gate_ls_b = gates.ls_b;
  assign prot_pull = therm_fault;

endmodule

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb;

  localparam int D = 75;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic       dir_rev = 1'b0;
  logic       enable = 1'b1;
  logic       therm_fault = 1'b0;
  logic       hs_a, hs_b, ls_a, ls_b, prot;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model of the accepted request and the quiet time since the last disturbance
  logic [2:0] m_held = 3'b000;
  int         m_since = 0;

  always #2 clk = ~clk;

  hbridge_gate_seq #(.DEAD_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .dir_rev(dir_rev),
    .enable(enable), .therm_fault(therm_fault),
    .gate_hs_a(hs_a), .gate_hs_b(hs_b), .gate_ls_a(ls_a), .gate_ls_b(ls_b),
    .prot_pull(prot)
  );

  function automatic logic [3:0] pattern_of(logic [2:0] mr);
    case (mr)
      3'b010:  return 4'b1001;
      3'b011:  return 4'b0110;
      3'b100,
      3'b101:  return 4'b0011;
      3'b110:  return 4'b0110;
      3'b111:  return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] model_gates();
    if (enable && !therm_fault && ({mode_req, dir_rev} == m_held) && (m_since >= D))
      return pattern_of(m_held);
    return 4'b0000;
  endfunction

  function automatic logic [3:0] gv();
    return {hs_a, hs_b, ls_a, ls_b};
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_held = 3'b000; m_since = 0;
    end else if (!enable || therm_fault) begin
      m_since = 0;
    end else if ({mode_req, dir_rev} != m_held) begin
      m_held = {mode_req, dir_rev}; m_since = 0;
    end else if (m_since < D) begin
      m_since++;
    end
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1337);
    @(negedge clk);
    steps(3);
    chk("R9 reset gates", gv(), 4'b0000);
    chk("R9 reset prot", {3'b000, prot}, 4'b0000);
    rst_n = 1'b1;
    steps(D + 2);
    chk("R9 after reset off request", gv(), 4'b0000);

    // R1 / R2: every mode in both directions, with the dead time edge count of R3
    for (int d = 0; d < 2; d++) begin
      for (int m = 1; m < 4; m++) begin
        mode_req = m[1:0]; dir_rev = d[0];
        #1 chk("R3 immediate off on change", gv(), 4'b0000);
        steps(D);
        chk("R3 still blank after DEAD_CYC edges", gv(), 4'b0000);
        step();
        chk(d == 0 ? "R1 forward pattern" : "R2 reverse pattern", gv(),
            pattern_of({m[1:0], d[0]}));
      end
    end
    mode_req = 2'b00; dir_rev = 1'b0;
    steps(D + 1);
    chk("R1 off pattern", gv(), 4'b0000);

    // R7: restart during blanking, latest wins
    mode_req = 2'b01;
    steps(D + 1);
    chk("R1 charge before restart test", gv(), 4'b1001);
    mode_req = 2'b11;
    steps(20);
    chk("R7 blank mid wait", gv(), 4'b0000);
    mode_req = 2'b01; dir_rev = 1'b1;
    steps(D);
    chk("R7 restarted wait still blank", gv(), 4'b0000);
    step();
    chk("R7 latest request applied", gv(), 4'b0110);

    // R4 / R8: enable
    enable = 1'b0;
    #1 chk("R4 enable low immediate off", gv(), 4'b0000);
    steps(5);
    chk("R4 enable low held off", gv(), 4'b0000);
    enable = 1'b1;
    steps(D - 1);
    chk("R8 enable recovery blank", gv(), 4'b0000);
    step();
    chk("R8 enable recovery pattern", gv(), 4'b0110);

    // R6 / R8: thermal fault
    therm_fault = 1'b1;
    #1 chk("R6 fault immediate off", gv(), 4'b0000);
    chk("R6 protect driven", {3'b000, prot}, 4'b0001);
    steps(4);
    therm_fault = 1'b0;
    #1 chk("R6 protect released", {3'b000, prot}, 4'b0000);
    steps(D - 1);
    chk("R8 fault recovery blank", gv(), 4'b0000);
    step();
    chk("R8 fault recovery pattern", gv(), 4'b0110);

    // random phase against the bench model, every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[5:0] == 6'd0) begin
        mode_req = r[7:6]; dir_rev = r[8];
      end
      if (r[16:9] < 8'd2) enable = ~enable;
      if (r[24:17] < 8'd1) therm_fault = ~therm_fault;
      if (!enable && r[30:25] == 6'd0) enable = 1'b1;
      #1;
      chk("R1 R2 R3 R7 R8 random model", gv(), model_gates());
      chk("R5 leg exclusion", {2'b00, hs_a & ls_a, hs_b & ls_b}, 4'b0000);
      chk("R6 protect follows fault", {3'b000, prot}, {3'b000, therm_fault});
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule